// File: doc/BRIEF.md
# Event Switch Unit

The event switch unit sits next to one processor core and lets a single hardware event move execution off the main code path onto a handler path. Software arms the unit by naming a trigger source, a handler address and an occurrence count. The main path then runs at full speed with no polling and no stall. When the chosen event has happened the requested number of times, the unit asks the core to load the handler address into its program counter. At that moment it captures the main path's program counter and switches the core to a second flag set. The handler ends by pulsing a done strobe. The unit then asks the core to jump back to the captured address and restores the main flag set.

There is one level only. There is no vector table, no register stacking and no nesting. An event that arrives while the handler owns the core is remembered. It is replayed as soon as the main path resumes, but only if the handler re-armed the unit. Three trigger sources are supported: a selected input pin edge, a counter overflow pulse, and a read or write to one programmed shared-memory word address.

Top module: `evsw_unit`

## Requirements
- R1: With source code 1 (overflow) armed and a count of 1, an overflow pulse sampled at clock edge k sets `ovr_req_o` after edge k, with `ovr_pc_o` equal to the armed handler address and `flag_sel_o` still 0.
- R2: With source code 0 (pin), the pin picked by `arm_pin_i` passes through two synchronizer flops. A level change present before edge k raises `ovr_req_o` after edge k+2. `arm_fall_i`=0 selects rising edges and 1 selects falling edges; the opposite edge does not fire.
- R3: With source code 2 (memory), an event is a cycle in which `mon_rd_i` or `mon_wr_i` is high and `mon_addr_i` equals the armed address in every bit. An address mismatch, or a match with no strobe, does not fire.
- R4: When the switch request is acknowledged, `core_pc_i` of that cycle is stored and shown on `ret_pc_o`, and it stays unchanged while the handler runs. A `done_i` pulse in the handler raises `ovr_req_o` with `ovr_pc_o` equal to that stored address.
- R5: `flag_sel_o` goes to 1 on the edge that accepts the switch acknowledge. It goes back to 0 on the edge that accepts the return acknowledge.
- R6: `ovr_req_o` and `ovr_pc_o` hold until `ack_i` is sampled high, and the request falls on that edge. Firing disarms the unit, so one arm yields one switch.
- R7: A count of N≥2 fires on the Nth qualifying event. A count of 0 or 1 fires on the first.
- R8: Arming replaces the source, address and count, and restarts the occurrence count from zero. If an arm and an event share a cycle, the event is not counted.
- R9: No switch request occurs while the handler is active. An event seen in that time is pending. It fires one cycle after the return acknowledge if the unit was re-armed (count 1), and it is dropped otherwise.
- R10: After reset, `ovr_req_o` and `flag_sel_o` are 0. `done_i` and `ack_i` on the main path have no effect, and an armed unit with no event never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPIN | Asynchronous pin levels |
| ovf_i | input | 1 | Counter overflow pulse |
| mon_addr_i | input | MEM_AW | Shared-memory word address being accessed |
| mon_rd_i | input | 1 | Shared-memory read strobe |
| mon_wr_i | input | 1 | Shared-memory write strobe |
| arm_i | input | 1 | Arm strobe: load the fields below |
| arm_src_i | input | 2 | Source: 0 pin, 1 overflow, 2 memory |
| arm_pin_i | input | PSEL_W | Pin index for the pin source |
| arm_fall_i | input | 1 | 1 selects falling edges, 0 selects rising edges |
| arm_count_i | input | CNT_W | Occurrence count qualifier |
| arm_target_i | input | PC_W | Handler start address |
| arm_maddr_i | input | MEM_AW | Watched shared-memory address |
| core_pc_i | input | PC_W | Main path resume address offered by the core |
| ack_i | input | 1 | Core took the PC override at an instruction boundary |
| done_i | input | 1 | Handler clears the event and asks to return |
| ovr_req_o | output | 1 | PC override request |
| ovr_pc_o | output | PC_W | Address for the override |
| ret_pc_o | output | PC_W | Captured main path address |
| flag_sel_o | output | 1 | 1 when the handler flag set is active |

## Verification
The bench drives the corners that a subtly wrong switch would mishandle. An event arriving inside the handler must neither nest nor be lost when the handler re-arms; a design without the pending latch would never fire after return. It also checks that a stale event is discarded when the handler does not re-arm; a design with a sticky pending bit would fire spuriously on the next arm. The count qualifier is run across a re-arm, where a design that keeps the old count fires one or two events too early. The opposite pin edge and one-bit address mismatches are applied, where loose decoding would switch on the wrong event. The request is held without acknowledge for several cycles, where a design that treats it as a bare pulse would drop it or capture the return address too early.

// File: rtl/evsw_pkg.sv
package evsw_pkg;

    typedef enum logic [1:0] {
        ST_MAIN    = 2'd0,
        ST_ENTER   = 2'd1,
        ST_HANDLER = 2'd2,
        ST_LEAVE   = 2'd3
    } evsw_state_e;

    localparam logic [1:0] SRC_PIN = 2'd0;
    localparam logic [1:0] SRC_OVF = 2'd1;
    localparam logic [1:0] SRC_MEM = 2'd2;

endpackage

// File: rtl/evsw_pin_edge.sv
module evsw_pin_edge #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] rise_o,
    output logic [NPIN-1:0] fall_o
);

    typedef struct packed {
        logic [NPIN-1:0] meta;
        logic [NPIN-1:0] sync;
        logic [NPIN-1:0] prev;
    } edge_regs_t;

    edge_regs_t d, q;

    always_comb begin
        d      = q;
        d.meta = pin_i;
        d.sync = q.meta;
        d.prev = q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_edge
        assign rise_o[g] =  q.sync[g] & ~q.prev[g];
        assign fall_o[g] = ~q.sync[g] &  q.prev[g];
    end

endmodule

// File: rtl/evsw_trig_sel.sv
module evsw_trig_sel
    import evsw_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int MEM_AW = 20,
    localparam int PSEL_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic [1:0]        src_i,
    input  logic [PSEL_W-1:0] psel_i,
    input  logic              fall_sel_i,
    input  logic [MEM_AW-1:0] maddr_i,
    input  logic [NPIN-1:0]   rise_i,
    input  logic [NPIN-1:0]   fall_i,
    input  logic              ovf_i,
    input  logic [MEM_AW-1:0] mon_addr_i,
    input  logic              mon_rd_i,
    input  logic              mon_wr_i,
    output logic              trig_o
);

    logic pin_hit;
    logic mem_hit;

    always_comb begin
        pin_hit = fall_sel_i ? fall_i[psel_i] : rise_i[psel_i];
        mem_hit = (mon_rd_i | mon_wr_i) && (mon_addr_i == maddr_i);
        unique case (src_i)
            SRC_PIN: trig_o = pin_hit;
            SRC_OVF: trig_o = ovf_i;
            SRC_MEM: trig_o = mem_hit;
            default: trig_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/evsw_ctrl.sv
module evsw_ctrl
    import evsw_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int MEM_AW = 20,
    parameter int PC_W   = 16,
    parameter int CNT_W  = 8,
    localparam int PSEL_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              arm_i,
    input  logic [1:0]        arm_src_i,
    input  logic [PSEL_W-1:0] arm_pin_i,
    input  logic              arm_fall_i,
    input  logic [CNT_W-1:0]  arm_count_i,
    input  logic [PC_W-1:0]   arm_target_i,
    input  logic [MEM_AW-1:0] arm_maddr_i,
    input  logic [PC_W-1:0]   core_pc_i,
    input  logic              ack_i,
    input  logic              done_i,
    output logic [1:0]        src_o,
    output logic [PSEL_W-1:0] psel_o,
    output logic              fall_sel_o,
    output logic [MEM_AW-1:0] maddr_o,
    output logic              ovr_req_o,
    output logic [PC_W-1:0]   ovr_pc_o,
    output logic [PC_W-1:0]   ret_pc_o,
    output logic              flag_sel_o
);

    localparam int CW1 = CNT_W + 1;

    typedef struct packed {
        evsw_state_e       st;
        logic              armed;
        logic              pend;
        logic              req;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  limit;
        logic [PC_W-1:0]   target;
        logic [PC_W-1:0]   jmp;
        logic [PC_W-1:0]   retpc;
        logic [1:0]        src;
        logic [PSEL_W-1:0] psel;
        logic              fall_sel;
        logic [MEM_AW-1:0] maddr;
    } ctrl_regs_t;

    ctrl_regs_t d, q;

    logic [CW1-1:0] cnt_next;
    logic [CW1-1:0] limit_eff;
    logic           reached;

    always_comb begin
        cnt_next  = {1'b0, q.cnt} + CW1'(1);
        limit_eff = (q.limit == '0) ? CW1'(1) : {1'b0, q.limit};
        reached   = (cnt_next >= limit_eff);
    end

    always_comb begin
        d = q;

        if (arm_i) begin
            d.armed    = 1'b1;
            d.cnt      = '0;
            d.limit    = arm_count_i;
            d.target   = arm_target_i;
            d.src      = arm_src_i;
            d.psel     = arm_pin_i;
            d.fall_sel = arm_fall_i;
            d.maddr    = arm_maddr_i;
        end

        unique case (q.st)
            ST_MAIN: begin
                d.pend = 1'b0;
                if (!arm_i && q.armed && (trig_i || q.pend)) begin
                    if (reached) begin
                        d.armed = 1'b0;
                        d.cnt   = '0;
                        d.req   = 1'b1;
                        d.jmp   = q.target;
                        d.st    = ST_ENTER;
                    end else begin
                        d.cnt = cnt_next[CNT_W-1:0];
                    end
                end
            end
            ST_ENTER: begin
                if (trig_i) begin
                    d.pend = 1'b1;
                end
                if (ack_i) begin
                    d.retpc = core_pc_i;
                    d.req   = 1'b0;
                    d.st    = ST_HANDLER;
                end
            end
            ST_HANDLER: begin
                if (trig_i) begin
                    d.pend = 1'b1;
                end
                if (done_i) begin
                    d.req = 1'b1;
                    d.st  = ST_LEAVE;
                end
            end
            ST_LEAVE: begin
                if (trig_i) begin
                    d.pend = 1'b1;
                end
                if (ack_i) begin
                    d.req = 1'b0;
                    d.st  = ST_MAIN;
                end
            end
            default: d.st = ST_MAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign src_o      = q.src;
    assign psel_o     = q.psel;
    assign fall_sel_o = q.fall_sel;
    assign maddr_o    = q.maddr;
    assign ovr_req_o  = q.req;
    assign ovr_pc_o   = (q.st == ST_LEAVE) ? q.retpc : q.jmp;
    assign ret_pc_o   = q.retpc;
    assign flag_sel_o = (q.st == ST_HANDLER) || (q.st == ST_LEAVE);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_req_o && !ack_i |=> ovr_req_o && $stable(ovr_pc_o)); // R6

    AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_req_o) && !flag_sel_o |-> !q.armed); // R6

    AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_req_o && flag_sel_o |-> ovr_pc_o == ret_pc_o); // R9

    AST_RET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sel_o |=> $stable(ret_pc_o)); // R4

    AST_FLAGS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_sel_o) |-> $past(ovr_req_o && ack_i)); // R5

endmodule

// File: rtl/evsw_unit.sv
module evsw_unit #(
    parameter int NPIN   = 8,
    parameter int MEM_AW = 20,
    parameter int PC_W   = 16,
    parameter int CNT_W  = 8,
    localparam int PSEL_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_i,
    input  logic              ovf_i,
    input  logic [MEM_AW-1:0] mon_addr_i,
    input  logic              mon_rd_i,
    input  logic              mon_wr_i,
    input  logic              arm_i,
    input  logic [1:0]        arm_src_i,
    input  logic [PSEL_W-1:0] arm_pin_i,
    input  logic              arm_fall_i,
    input  logic [CNT_W-1:0]  arm_count_i,
    input  logic [PC_W-1:0]   arm_target_i,
    input  logic [MEM_AW-1:0] arm_maddr_i,
    input  logic [PC_W-1:0]   core_pc_i,
    input  logic              ack_i,
    input  logic              done_i,
    output logic              ovr_req_o,
    output logic [PC_W-1:0]   ovr_pc_o,
    output logic [PC_W-1:0]   ret_pc_o,
    output logic              flag_sel_o
);

    logic [NPIN-1:0]   rise;
    logic [NPIN-1:0]   fall;
    logic              trig;
    logic [1:0]        cfg_src;
    logic [PSEL_W-1:0] cfg_psel;
    logic              cfg_fall;
    logic [MEM_AW-1:0] cfg_maddr;

    evsw_pin_edge #(.NPIN(NPIN)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    evsw_trig_sel #(.NPIN(NPIN), .MEM_AW(MEM_AW)) u_sel (
        .src_i      (cfg_src),
        .psel_i     (cfg_psel),
        .fall_sel_i (cfg_fall),
        .maddr_i    (cfg_maddr),
        .rise_i     (rise),
        .fall_i     (fall),
        .ovf_i      (ovf_i),
        .mon_addr_i (mon_addr_i),
        .mon_rd_i   (mon_rd_i),
        .mon_wr_i   (mon_wr_i),
        .trig_o     (trig)
    );

    evsw_ctrl #(.NPIN(NPIN), .MEM_AW(MEM_AW), .PC_W(PC_W), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig),
        .arm_i        (arm_i),
        .arm_src_i    (arm_src_i),
        .arm_pin_i    (arm_pin_i),
        .arm_fall_i   (arm_fall_i),
        .arm_count_i  (arm_count_i),
        .arm_target_i (arm_target_i),
        .arm_maddr_i  (arm_maddr_i),
        .core_pc_i    (core_pc_i),
        .ack_i        (ack_i),
        .done_i       (done_i),
        .src_o        (cfg_src),
        .psel_o       (cfg_psel),
        .fall_sel_o   (cfg_fall),
        .maddr_o      (cfg_maddr),
        .ovr_req_o    (ovr_req_o),
        .ovr_pc_o     (ovr_pc_o),
        .ret_pc_o     (ret_pc_o),
        .flag_sel_o   (flag_sel_o)
    );

endmodule

// File: tb/evsw_unit_tb_top.sv
module evsw_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = '0;
    logic        ovf_i = 1'b0;
    logic [19:0] mon_addr_i = '0;
    logic        mon_rd_i = 1'b0;
    logic        mon_wr_i = 1'b0;
    logic        arm_i = 1'b0;
    logic [1:0]  arm_src_i = '0;
    logic [2:0]  arm_pin_i = '0;
    logic        arm_fall_i = 1'b0;
    logic [7:0]  arm_count_i = '0;
    logic [15:0] arm_target_i = '0;
    logic [19:0] arm_maddr_i = '0;
    logic [15:0] core_pc_i = '0;
    logic        ack_i = 1'b0;
    logic        done_i = 1'b0;
    logic        ovr_req_o;
    logic [15:0] ovr_pc_o;
    logic [15:0] ret_pc_o;
    logic        flag_sel_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    evsw_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .ovf_i(ovf_i),
        .mon_addr_i(mon_addr_i), .mon_rd_i(mon_rd_i), .mon_wr_i(mon_wr_i),
        .arm_i(arm_i), .arm_src_i(arm_src_i), .arm_pin_i(arm_pin_i),
        .arm_fall_i(arm_fall_i), .arm_count_i(arm_count_i),
        .arm_target_i(arm_target_i), .arm_maddr_i(arm_maddr_i),
        .core_pc_i(core_pc_i), .ack_i(ack_i), .done_i(done_i),
        .ovr_req_o(ovr_req_o), .ovr_pc_o(ovr_pc_o), .ret_pc_o(ret_pc_o),
        .flag_sel_o(flag_sel_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input logic [1:0] src, input logic [2:0] psel, input logic fal,
                       input logic [7:0] cnt, input logic [15:0] tgt, input logic [19:0] ma);
        arm_i = 1'b1; arm_src_i = src; arm_pin_i = psel; arm_fall_i = fal;
        arm_count_i = cnt; arm_target_i = tgt; arm_maddr_i = ma;
        step(1);
        arm_i = 1'b0;
    endtask

    task automatic pulse_ovf();
        ovf_i = 1'b1; step(1); ovf_i = 1'b0;
    endtask

    task automatic do_ack(input logic [15:0] pc);
        ack_i = 1'b1; core_pc_i = pc; step(1); ack_i = 1'b0;
    endtask

    task automatic do_done();
        done_i = 1'b1; step(1); done_i = 1'b0;
    endtask

    task automatic run_handler(input logic [15:0] pc);
        do_ack(pc);
        chk("R5 flag set in handler", 32'(flag_sel_o), 1);
        chk("R4 ret pc captured", 32'(ret_pc_o), 32'(pc));
        do_done();
        chk("R4 return request", 32'(ovr_req_o), 1);
        chk("R4 return target", 32'(ovr_pc_o), 32'(pc));
        do_ack(16'h0);
        chk("R5 flag back to main", 32'(flag_sel_o), 0);
        chk("R6 request dropped after ack", 32'(ovr_req_o), 0);
    endtask

    task automatic t_reset();
        chk("R10 reset req", 32'(ovr_req_o), 0);
        chk("R10 reset flag", 32'(flag_sel_o), 0);
    endtask

    task automatic t_basic_ovf();
        done_i = 1'b1; ack_i = 1'b1; step(1); done_i = 1'b0; ack_i = 1'b0;
        chk("R10 done/ack in main ignored", 32'({ovr_req_o, flag_sel_o}), 0);
        arm(2'd1, 3'd0, 1'b0, 8'd1, 16'h0100, 20'h0);
        step(5);
        chk("R10 armed, no event, no request", 32'(ovr_req_o), 0);
        pulse_ovf();
        chk("R1 overflow fires", 32'(ovr_req_o), 1);
        chk("R1 handler target", 32'(ovr_pc_o), 32'h0100);
        chk("R5 flags still main before ack", 32'(flag_sel_o), 0);
        step(3);
        chk("R6 request held without ack", 32'(ovr_req_o), 1);
        chk("R6 target held", 32'(ovr_pc_o), 32'h0100);
        run_handler(16'h0042);
        pulse_ovf();
        chk("R6 fires once per arm", 32'(ovr_req_o), 0);
    endtask

    task automatic t_count();
        arm(2'd1, 3'd0, 1'b0, 8'd3, 16'h0200, 20'h0);
        pulse_ovf(); step(1); pulse_ovf();
        chk("R7 two of three events", 32'(ovr_req_o), 0);
        pulse_ovf();
        chk("R7 third event fires", 32'(ovr_req_o), 1);
        run_handler(16'h0050);
        arm(2'd1, 3'd0, 1'b0, 8'd3, 16'h0300, 20'h0);
        pulse_ovf(); pulse_ovf();
        arm(2'd1, 3'd0, 1'b0, 8'd3, 16'h0310, 20'h0);
        pulse_ovf(); pulse_ovf();
        chk("R8 rearm restarts count", 32'(ovr_req_o), 0);
        pulse_ovf();
        chk("R8 fires after new count", 32'(ovr_req_o), 1);
        chk("R8 new target", 32'(ovr_pc_o), 32'h0310);
        run_handler(16'h0051);
        arm(2'd1, 3'd0, 1'b0, 8'd0, 16'h0320, 20'h0);
        pulse_ovf();
        chk("R7 count zero fires first", 32'(ovr_req_o), 1);
        run_handler(16'h0052);
    endtask

    task automatic t_pin();
        arm(2'd0, 3'd2, 1'b0, 8'd1, 16'h0400, 20'h0);
        pin_i[3] = 1'b1;
        step(4);
        chk("R2 other pin ignored", 32'(ovr_req_o), 0);
        pin_i[3] = 1'b0;
        pin_i[2] = 1'b1;
        step(2);
        chk("R2 not before sync latency", 32'(ovr_req_o), 0);
        step(1);
        chk("R2 rising edge fires", 32'(ovr_req_o), 1);
        run_handler(16'h0060);
        arm(2'd0, 3'd5, 1'b1, 8'd1, 16'h0500, 20'h0);
        pin_i[5] = 1'b1;
        step(4);
        chk("R2 rising ignored in falling mode", 32'(ovr_req_o), 0);
        pin_i[5] = 1'b0;
        step(3);
        chk("R2 falling edge fires", 32'(ovr_req_o), 1);
        chk("R2 falling target", 32'(ovr_pc_o), 32'h0500);
        run_handler(16'h0061);
        pin_i = '0;
        step(3);
    endtask

    task automatic t_mem();
        arm(2'd2, 3'd0, 1'b0, 8'd1, 16'h0600, 20'h01234);
        mon_addr_i = 20'h01235; mon_wr_i = 1'b1; step(1);
        mon_addr_i = 20'h11234; step(1);
        mon_wr_i = 1'b0; mon_addr_i = 20'h01234; step(1);
        chk("R3 mismatch or no strobe ignored", 32'(ovr_req_o), 0);
        mon_rd_i = 1'b1; step(1); mon_rd_i = 1'b0;
        chk("R3 read match fires", 32'(ovr_req_o), 1);
        run_handler(16'h0070);
        arm(2'd2, 3'd0, 1'b0, 8'd1, 16'h0610, 20'h01234);
        mon_wr_i = 1'b1; step(1); mon_wr_i = 1'b0;
        chk("R3 write match fires", 32'(ovr_req_o), 1);
        run_handler(16'h0071);
    endtask

    task automatic t_pending();
        arm(2'd1, 3'd0, 1'b0, 8'd1, 16'h0700, 20'h0);
        pulse_ovf();
        do_ack(16'h0080);
        arm(2'd1, 3'd0, 1'b0, 8'd1, 16'h0710, 20'h0);
        pulse_ovf();
        step(1);
        chk("R9 no nested request", 32'(ovr_req_o), 0);
        do_done();
        do_ack(16'h0);
        chk("R9 main resumes first", 32'(ovr_req_o), 0);
        step(1);
        chk("R9 pending delivered after rearm", 32'(ovr_req_o), 1);
        chk("R9 pending target", 32'(ovr_pc_o), 32'h0710);
        do_ack(16'h0081);
        pulse_ovf();
        do_done();
        do_ack(16'h0);
        step(3);
        chk("R9 pending dropped when not rearmed", 32'(ovr_req_o), 0);
        arm(2'd1, 3'd0, 1'b0, 8'd1, 16'h0720, 20'h0);
        step(3);
        chk("R9 stale pending not replayed", 32'(ovr_req_o), 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_basic_ovf();
        t_count();
        t_pin();
        t_mem();
        t_pending();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule